// File: doc/BRIEF.md
# Three-Clock Level-Sensitive Scan Chain

This block is a parameterised chain of scan storage elements, each split into a master stage and a slave stage. Three clock enables steer it: a capture enable, a shift enable and an update enable, all sampled on one system clock. The master stage has two ports. It takes the functional data input on capture, or the scan data on shift. The slave stage copies the master on update, and its value is the output the surrounding logic sees.

The cells are chained for serial access. The slave of each cell feeds the shift port of the next cell. The first cell takes the serial scan input, and the last slave drives the serial scan output. Shifting is done by alternating shift and update pulses, so the pattern moves one cell per pulse pair. Capture is done by alternating capture and update pulses.

Two sticky error flags report enables used together in the same cycle. When that happens, the affected stage keeps its value.

Top module: `lssd_chain`

## Requirements
- R1: While the internal reset is active, every master stage, every slave stage and both error flags are cleared. An update pulse just after reset therefore drives all zeros on `cell_q`.
- R2: A cycle with `cap_en`=1 and `shf_en`=0 loads `cell_d[i]` into master i. `cell_q` does not change unless an update is also applied.
- R3: A cycle with `upd_en`=1 and both other enables at 0 copies every master into its slave. The new value shows on `cell_q` after that clock edge.
- R4: A cycle with `shf_en`=1 and `cap_en`=0 loads master 0 from `scan_in` and master i from slave i-1 (for i>0). After a following update, the chain has moved one cell toward `scan_out`.
- R5: `scan_out` always equals `cell_q[N-1]`, the slave of the last cell.
- R6: A cycle with both `cap_en` and `shf_en` set leaves every master unchanged and sets `err_conflict`. The flag then stays at 1 until reset.
- R7: A cycle with `upd_en` set together with `cap_en` or `shf_en` leaves every slave unchanged and sets `err_overlap`. The flag then stays at 1 until reset. The master action of that cycle still follows R2, R4 and R6.
- R8: A cycle with no enable set changes no stage and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised to clk |
| cap_en | input | 1 | Capture enable: masters load functional data |
| shf_en | input | 1 | Shift enable: masters load scan data |
| upd_en | input | 1 | Update enable: slaves copy masters |
| cell_d | input | N_CELLS | Functional data input, one bit per cell |
| scan_in | input | 1 | Serial scan input to cell 0 |
| cell_q | output | N_CELLS | Slave values, one bit per cell |
| scan_out | output | 1 | Serial scan output (slave of the last cell) |
| err_conflict | output | 1 | Sticky: capture and shift were requested in the same cycle |
| err_overlap | output | 1 | Sticky: update coincided with capture or shift |

## Verification
The in-line assertions check every cycle's local rules. A clean capture or shift loads the right source, a clean update copies the master, and a collision freezes the affected stage. Both flags stay sticky. What the assertions cannot show is the combined behaviour across many cycles. Only the bench scenarios show that a serial pattern really walks along the chain, that captured data appears after the later update, and that reset clears masters that are not directly visible. The bench checks these against a reference model driven by random and directed enable sequences.

// File: rtl/lssd_pkg.sv
package lssd_pkg;

  // Clock enables of one cycle, shared by every cell.
  typedef struct packed {
    logic cap;
    logic shf;
    logic upd;
  } lssd_en_t;

  // Master action is legal only when exactly one master enable is set.
  function automatic logic master_collide(lssd_en_t e);
    return e.cap & e.shf;
  endfunction

  // Slave must stay still while any master enable is set.
  function automatic logic slave_collide(lssd_en_t e);
    return e.upd & (e.cap | e.shf);
  endfunction

endpackage

// File: rtl/lssd_rst_sync.sv
module lssd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lssd_cell.sv
module lssd_cell
  import lssd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lssd_en_t en,
  input  logic     func_d,
  input  logic     scan_d,
  output logic     slave_q
);

  logic master_q, master_d;
  logic slave_d;

  always_comb begin
    master_d = master_q;
    if (!master_collide(en)) begin
      if (en.cap)      master_d = func_d;
      else if (en.shf) master_d = scan_d;
    end
  end

  always_comb begin
    slave_d = slave_q;
    if (en.upd && !slave_collide(en)) slave_d = master_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      slave_q  <= 1'b0;
    end else begin
      master_q <= master_d;
      slave_q  <= slave_d;
    end
  end

  a_r2_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
    (en.cap && !en.shf) |=> (master_q == $past(func_d)));

  a_r4_shift_load: assert property (@(posedge clk) disable iff (!rst_n)
    (en.shf && !en.cap) |=> (master_q == $past(scan_d)));

  a_r3_update_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (en.upd && !en.cap && !en.shf) |=> (slave_q == $past(master_q)));

  a_r6_master_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en.cap && en.shf) |=> $stable(master_q));

  a_r7_slave_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en.upd && (en.cap || en.shf)) |=> $stable(slave_q));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en.upd && !en.cap && !en.shf) |=> ($stable(master_q) && $stable(slave_q)));

endmodule

// File: rtl/lssd_guard.sv
module lssd_guard
  import lssd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lssd_en_t en,
  output logic     conflict_q,
  output logic     overlap_q
);

  logic conflict_d, overlap_d;

  always_comb begin
    conflict_d = conflict_q | master_collide(en);
    overlap_d  = overlap_q  | slave_collide(en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conflict_q <= 1'b0;
      overlap_q  <= 1'b0;
    end else begin
      conflict_q <= conflict_d;
      overlap_q  <= overlap_d;
    end
  end

  a_r6_conflict_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_q |=> conflict_q);

  a_r6_conflict_set: assert property (@(posedge clk) disable iff (!rst_n)
    (en.cap && en.shf) |=> conflict_q);

  a_r7_overlap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_q |=> overlap_q);

  a_r7_overlap_set: assert property (@(posedge clk) disable iff (!rst_n)
    (en.upd && (en.cap || en.shf)) |=> overlap_q);

endmodule

// File: rtl/lssd_chain.sv
module lssd_chain
  import lssd_pkg::*;
#(
  parameter int N_CELLS   = 3,
  parameter int RST_SYNC  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_en,
  input  logic               shf_en,
  input  logic               upd_en,
  input  logic [N_CELLS-1:0] cell_d,
  input  logic               scan_in,
  output logic [N_CELLS-1:0] cell_q,
  output logic               scan_out,
  output logic               err_conflict,
  output logic               err_overlap
);

  localparam int LAST = N_CELLS - 1;

  logic                rst_core_n;
  lssd_en_t            en;
  logic [N_CELLS-1:0]  slave_v;
  logic [N_CELLS-1:0]  scan_feed;

  assign en = '{cap: cap_en, shf: shf_en, upd: upd_en};

  lssd_rst_sync #(.STAGES(RST_SYNC)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  generate
    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
      if (i == 0) begin : g_head
        assign scan_feed[i] = scan_in;
      end else begin : g_link
        assign scan_feed[i] = slave_v[i-1];
      end
      lssd_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_core_n),
        .en      (en),
        .func_d  (cell_d[i]),
        .scan_d  (scan_feed[i]),
        .slave_q (slave_v[i])
      );
    end
  endgenerate

  lssd_guard u_guard (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .en         (en),
    .conflict_q (err_conflict),
    .overlap_q  (err_overlap)
  );

  assign cell_q   = slave_v;
  assign scan_out = slave_v[LAST];

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_core_n |=> (cell_q == '0 && !err_conflict && !err_overlap));

  a_r5_scan_out_tap: assert property (@(posedge clk) disable iff (!rst_core_n)
    (shf_en && !cap_en) |=> (scan_out == cell_q[LAST]));

endmodule

// File: tb/lssd_chain_tb.sv
module lssd_chain_tb;

  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cap_en = 1'b0, shf_en = 1'b0, upd_en = 1'b0;
  logic [N-1:0] cell_d = '0;
  logic         scan_in = 1'b0;
  logic [N-1:0] cell_q;
  logic         scan_out, err_conflict, err_overlap;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  logic [N-1:0] m_mod, s_mod;
  logic         fc_mod, fo_mod;

  always #4 clk = ~clk;

  lssd_chain #(.N_CELLS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .shf_en(shf_en), .upd_en(upd_en),
    .cell_d(cell_d), .scan_in(scan_in), .cell_q(cell_q), .scan_out(scan_out),
    .err_conflict(err_conflict), .err_overlap(err_overlap)
  );

  function automatic logic [N-1:0] next_master(logic [N-1:0] m, logic [N-1:0] s,
      logic c, logic sh, logic [N-1:0] d, logic si);
    logic [N-1:0] r;
    r = m;
    if (c && !sh) r = d;
    else if (sh && !c) r = {s[N-2:0], si};
    return r;
  endfunction

  function automatic logic [N-1:0] next_slave(logic [N-1:0] m, logic [N-1:0] s,
      logic c, logic sh, logic u);
    return (u && !c && !sh) ? m : s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, 32'(cell_q), 32'(s_mod));
    chk("R5", 32'(scan_out), 32'(s_mod[N-1]));
    chk("R6", 32'(err_conflict), 32'(fc_mod));
    chk("R7", 32'(err_overlap), 32'(fo_mod));
  endtask

  // Called at a negedge: drives one cycle, updates model, checks at next negedge.
  task automatic step(logic c, logic sh, logic u, logic [N-1:0] d, logic si, string tag);
    logic [N-1:0] nm, ns;
    cap_en = c; shf_en = sh; upd_en = u; cell_d = d; scan_in = si;
    nm = next_master(m_mod, s_mod, c, sh, d, si);
    ns = next_slave(m_mod, s_mod, c, sh, u);
    fc_mod = fc_mod | (c & sh);
    fo_mod = fo_mod | (u & (c | sh));
    m_mod = nm; s_mod = ns;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cap_en = 0; shf_en = 0; upd_en = 0;
    m_mod = '0; s_mod = '0; fc_mod = 0; fo_mod = 0;
    repeat (2) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic c, sh, u;
    seed = 32'd12345;
    void'($urandom(seed));
    m_mod = '0; s_mod = '0; fc_mod = 0; fo_mod = 0;

    do_reset();
    step(0, 0, 1, '0, 0, "R1");            // masters cleared: update gives zeros
    step(1, 0, 0, 3'b101, 0, "R2");        // capture, outputs unchanged
    step(0, 0, 1, '0, 0, "R2");            // now visible: 101
    step(0, 1, 0, '0, 0, "R4");            // shift in 0
    step(0, 0, 1, '0, 0, "R4");            // expect 010
    step(0, 1, 0, '0, 1, "R4");
    step(0, 0, 1, '0, 0, "R4");            // expect 101
    step(0, 0, 0, 3'b111, 1, "R8");
    step(0, 0, 0, 3'b000, 0, "R8");
    step(1, 1, 0, 3'b010, 1, "R6");        // conflict: masters hold
    step(0, 0, 1, '0, 0, "R6");            // slaves show held masters
    step(1, 0, 1, 3'b011, 0, "R7");        // overlap: slave holds, master loads
    step(0, 0, 1, '0, 0, "R7");            // now 011
    step(0, 1, 1, '0, 1, "R7");
    step(0, 0, 1, '0, 0, "R7");

    // Clean random operation: alternating master and update pulses.
    do_reset();
    for (int k = 0; k < 400; k++) begin
      if ($urandom % 2) step(1, 0, 0, N'($urandom), 1'($urandom), "R2");
      else              step(0, 1, 0, N'($urandom), 1'($urandom), "R4");
      step(0, 0, 1, N'($urandom), 1'($urandom), "R3");
      if ($urandom % 4 == 0) step(0, 0, 0, N'($urandom), 1'($urandom), "R8");
    end

    // Unconstrained enables, including collisions.
    do_reset();
    for (int k = 0; k < 600; k++) begin
      c = 1'($urandom); sh = 1'($urandom); u = 1'($urandom);
      step(c, sh, u, N'($urandom), 1'($urandom), (u && (c || sh)) ? "R7" : (c && sh) ? "R6" : "R3");
    end

    do_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule